// File: doc/BRIEF.md
# Cascadable TDM Serial Data Port

This block is the serial data port of one converter device on a shared four-wire time-division bus. The bus carries a shift clock, an active-low frame sync, a serial input and a serial output. Several devices can be chained on that bus, up to sixteen of them. When its frame sync goes low, the port claims a slot of sixteen shift clocks. During that slot it shifts a 16-bit two's-complement sample out on its serial output, most significant bit first, and takes in a 16-bit word from its serial input.

When its slot ends, the port drives its own active-low delayed frame sync for sixteen shift clocks. The frame sync it received had the same width. This delayed sync goes to the frame-sync input of the next device, so that device takes the following slot without any address decoding. The serial output is given an enable that is high only during the port's own slot, so a pad can tri-state it at all other times.

All bus pins are sampled in the core clock domain. The core clock must run at least eight times faster than the shift clock. Outgoing words enter through a valid/ready stream that has a one-word holding register. A word is accepted when `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` stays low from that acceptance until the next slot takes the word, so a producer that is early is held off rather than losing data. Received words leave as a one-cycle `rx_valid_o` strobe with no back-pressure. The consumer must take each word in the cycle it is presented.

Top module: `tdm_cascade_port`

## Requirements
- R1: After reset, `dout_oe_o` is 0, `fsd_n_o` is 1, `rx_valid_o` is 0 and `tx_ready_o` is 1.
- R2: A slot starts at the first SCLK rising edge where `fs_n_i` is seen low after it was seen high at the previous rising edge. A slot lasts 16 SCLK cycles. If `fs_n_i` stays low past the slot, no second slot starts.
- R3: During the slot, `dout_o` carries the transmit word MSB first and changes on SCLK rising edges: bit 15 in slot cycle 0, down to bit 0 in cycle 15. `dout_oe_o` is 1 for exactly those 16 cycles. Outside the slot, `dout_oe_o` is 0 and `dout_o` is 0.
- R4: `din_i` is sampled on the 16 SCLK falling edges of the slot, MSB first. The assembled word appears on `rx_data_o` with a `rx_valid_o` pulse of exactly one core-clock cycle, after bit 0 is captured and before the slot's enable drops.
- R5: `tx_ready_o` is 1 exactly when the holding register is empty. A word is accepted when `tx_valid_i` and `tx_ready_o` are both 1. After that, `tx_ready_o` stays 0, and `tx_valid_i` has no effect, until a slot start takes the word.
- R6: If the holding register is empty at slot start, the slot transmits 0x0000 and `tx_ready_o` stays 1.
- R7: The transmit word is copied at slot start. A word pushed later, or a change on `tx_data_i` during the slot, does not alter the bits sent in that slot.
- R8: `fsd_n_o` goes low on the SCLK rising edge right after the slot's 16th bit, in the same core cycle that `dout_oe_o` falls. It stays low for exactly 16 SCLK cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 8x the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Bus shift clock |
| fs_n_i | input | 1 | Active-low frame sync from the master or the previous device |
| din_i | input | 1 | Serial data into this device |
| dout_o | output | 1 | Serial data out of this device |
| dout_oe_o | output | 1 | Output enable for the serial output pad |
| fsd_n_o | output | 1 | Active-low delayed frame sync to the next device |
| tx_data_i | input | 16 | Transmit word, two's complement |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register empty, word can be accepted |
| rx_data_o | output | 16 | Received word, two's complement |
| rx_valid_o | output | 1 | One-cycle strobe marking a new received word |

## Verification
The assertions check the rules that hold on every cycle:
- the receive strobe lasts one cycle and falls inside the enabled slot;
- the slot enable and the delayed sync change over together in both directions;
- the serial output is quiet while disabled;
- an accepted word closes the ready signal.

Other behaviour depends on the bit order and the counting of shift clocks, so only the directed scenarios can show it:
- exact bit-by-bit serial contents;
- the sixteen-cycle widths;
- that a long frame sync gives one slot only;
- that the word sent is immune to pushes and data changes during the slot;
- the zero word on an empty holding register.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  localparam int DEF_WORD_W      = 16;
  localparam int DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
    logic fs_n;
    logic din;
  } tdm_evt_t;
endpackage

// File: rtl/tdm_front.sv
module tdm_front
  import tdm_port_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_i,
  input  logic     fs_n_i,
  input  logic     din_i,
  output tdm_evt_t evt_o
);
  localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [S-1:0] sclk_q, fs_q, din_q;
  logic         sclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      fs_q      <= '1;
      din_q     <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[S-2:0], sclk_i};
      fs_q      <= {fs_q[S-2:0], fs_n_i};
      din_q     <= {din_q[S-2:0], din_i};
      sclk_last <= sclk_q[S-1];
    end
  end

  always_comb begin
    evt_o.rise = sclk_q[S-1] & ~sclk_last;
    evt_o.fall = ~sclk_q[S-1] & sclk_last;
    evt_o.fs_n = fs_q[S-1];
    evt_o.din  = din_q[S-1];
  end
endmodule

// File: rtl/tdm_shift.sv
module tdm_shift
  import tdm_port_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tdm_evt_t          evt_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              slot_end_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] BITS    = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] BITS_M1 = CNT_W'(WORD_W - 1);

  logic              active, fs_prev, hold_full;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] tx_sh, rx_sh, hold;
  logic [WORD_W-1:0] first_word;
  logic              start, accept;

  assign start      = evt_i.rise & ~active & fs_prev & ~evt_i.fs_n;
  assign slot_end_o = evt_i.rise & active & (bit_cnt == BITS);
  assign accept     = tx_valid_i & ~hold_full;
  assign tx_ready_o = ~hold_full;
  assign first_word = hold_full ? hold : '0;

  // frame-sync history, sampled on each shift-clock rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fs_prev <= 1'b1;
    else if (evt_i.rise) fs_prev <= evt_i.fs_n;
  end

  // one-word transmit holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else begin
      if (start) hold_full <= 1'b0;
      if (accept) begin
        hold      <= tx_data_i;
        hold_full <= 1'b1;
      end
    end
  end

  // transmit side: slot tracking and serial output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      tx_sh     <= '0;
      dout_o    <= 1'b0;
      dout_oe_o <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      tx_sh     <= first_word;
      dout_o    <= first_word[WORD_W-1];
      dout_oe_o <= 1'b1;
    end else if (slot_end_o) begin
      active    <= 1'b0;
      dout_o    <= 1'b0;
      dout_oe_o <= 1'b0;
    end else if (evt_i.rise && active) begin
      dout_o <= tx_sh[WORD_W-2];
      tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

  // receive side: capture on falling edges, count bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (start) begin
        bit_cnt <= '0;
      end else if (evt_i.fall && active && (bit_cnt < BITS)) begin
        rx_sh   <= {rx_sh[WORD_W-2:0], evt_i.din};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BITS_M1) begin
          rx_data_o  <= {rx_sh[WORD_W-2:0], evt_i.din};
          rx_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_fsd.sv
module tdm_fsd #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic trig_i,
  output logic fsd_n_o
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsd_n_o <= 1'b1;
      cnt     <= '0;
    end else if (trig_i) begin
      fsd_n_o <= 1'b0;
      cnt     <= CNT_W'(1);
    end else if (rise_i && !fsd_n_o) begin
      if (cnt == LAST) begin
        fsd_n_o <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_cascade_port.sv
module tdm_cascade_port
  import tdm_port_pkg::*;
#(
  parameter int WORD_W      = DEF_WORD_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              fs_n_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              fsd_n_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  tdm_evt_t evt;
  logic     slot_end;

  tdm_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .fs_n_i (fs_n_i),
    .din_i  (din_i),
    .evt_o  (evt)
  );

  tdm_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o),
    .slot_end_o (slot_end)
  );

  tdm_fsd #(.LEN(WORD_W)) u_fsd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (evt.rise),
    .trig_i  (slot_end),
    .fsd_n_o (fsd_n_o)
  );
endmodule

// File: rtl/tdm_cascade_port_chk.sv
module tdm_cascade_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dout_o,
  input logic dout_oe_o,
  input logic fsd_n_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o
);
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);  // R4
  AST_RX_INSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> dout_oe_o);  // R4
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe_o |-> !dout_o);  // R3
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);  // R5
  AST_OE_DROP_FSD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe_o) |-> !fsd_n_o);  // R8
  AST_FSD_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsd_n_o) |-> $fell(dout_oe_o));  // R8
endmodule

bind tdm_cascade_port tdm_cascade_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dout_o     (dout_o),
  .dout_oe_o  (dout_oe_o),
  .fsd_n_o    (fsd_n_o),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/test_tdm_cascade_port.sv
module test_tdm_cascade_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NCYC       = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, fs_n = 1'b1, din = 1'b0;
  logic        dout, dout_oe, fsd_n, tx_ready, rx_valid, tx_valid = 1'b0;
  logic [15:0] tx_data = '0, rx_data;

  int errors = 0, checks = 0, rx_cnt = 0;
  logic [15:0] rx_last = '0;
  logic rec_dout [0:NCYC-1];
  logic rec_oe   [0:NCYC-1];
  logic rec_fsd  [0:NCYC-1];
  logic rec_rdy  [0:NCYC-1];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_cascade_port i_tdm_cascade_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fs_n_i(fs_n), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .fsd_n_o(fsd_n),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  always @(posedge clk) if (rst_n && rx_valid) begin
    rx_cnt  <= rx_cnt + 1;
    rx_last <= rx_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0; tx_data = ~w;
  endtask

  // one slot with fs_n low for fs_len cycles; optional push at cycle push_at
  task automatic run_frame(input logic [15:0] rxw, input int fs_len,
                           input int push_at, input logic [15:0] push_w);
    for (int i = 0; i < 2; i++) begin
      sclk = 1'b1; repeat (HALF) @(negedge clk);
      sclk = 1'b0; repeat (HALF) @(negedge clk);
    end
    fs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int c = 0; c < NCYC; c++) begin
      din  = (c < 16) ? rxw[15-c] : 1'b0;
      sclk = 1'b1;
      for (int k = 0; k < HALF; k++) begin
        if (k == 0 && c == push_at) begin
          tx_valid = 1'b1; tx_data = push_w;
        end
        @(negedge clk);
        if (k == 0 && c == push_at) begin
          tx_valid = 1'b0; tx_data = ~push_w;
        end
      end
      rec_dout[c] = dout; rec_oe[c] = dout_oe; rec_fsd[c] = fsd_n; rec_rdy[c] = tx_ready;
      sclk = 1'b0;
      fs_n = (c + 1 < fs_len) ? 1'b0 : 1'b1;
      repeat (HALF) @(negedge clk);
    end
    fs_n = 1'b1;
  endtask

  task automatic check_slot(input logic [15:0] txw, input string tag);
    for (int c = 0; c < NCYC; c++) begin
      if (c < 16) begin
        chk(rec_oe[c] === 1'b1, "R3 oe in slot", rec_oe[c], 1);
        chk(rec_dout[c] === txw[15-c], {"R3 ", tag}, rec_dout[c], txw[15-c]);
      end else begin
        chk(rec_oe[c] === 1'b0 && rec_dout[c] === 1'b0, "R3 quiet", {rec_oe[c], rec_dout[c]}, 0);
      end
      chk(rec_fsd[c] === ((c >= 16 && c < 32) ? 1'b0 : 1'b1), "R8 fsd window", rec_fsd[c],
          (c >= 16 && c < 32) ? 0 : 1);
    end
  endtask

  task automatic t_reset;
    chk(dout_oe === 1'b0, "R1 oe", dout_oe, 0);
    chk(fsd_n === 1'b1, "R1 fsd", fsd_n, 1);
    chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
  endtask

  task automatic t_basic(input logic [15:0] txw, input logic [15:0] rxw);
    int n0;
    push(txw);
    chk(tx_ready === 1'b0, "R5 full after push", tx_ready, 0);
    n0 = rx_cnt;
    run_frame(rxw, 16, -1, '0);
    check_slot(txw, "basic bits");
    chk(rx_cnt == n0 + 1, "R4 one strobe", rx_cnt - n0, 1);
    chk(rx_last === rxw, "R4 rx word", rx_last, rxw);
    chk(rec_rdy[0] === 1'b1, "R5 ready after start", rec_rdy[0], 1);
  endtask

  task automatic t_empty;
    run_frame(16'h0F0F, 16, -1, '0);
    check_slot(16'h0000, "R6 zero word");
    chk(rec_rdy[0] === 1'b1 && rec_rdy[20] === 1'b1, "R6 ready stays", rec_rdy[20], 1);
    chk(rx_last === 16'h0F0F, "R4 rx word", rx_last, 16'h0F0F);
  endtask

  task automatic t_midframe;
    push(16'h1357);
    run_frame(16'hAAAA, 16, 5, 16'hBEEF);
    check_slot(16'h1357, "R7 word kept");
    chk(rec_rdy[5] === 1'b0, "R5 closed after mid push", rec_rdy[5], 0);
    run_frame(16'h5555, 16, -1, '0);
    check_slot(16'hBEEF, "R7 next word");
  endtask

  task automatic t_backpressure;
    push(16'hC001);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 16'h7777;
    repeat (3) @(negedge clk);
    chk(tx_ready === 1'b0, "R5 held off", tx_ready, 0);
    tx_valid = 1'b0;
    run_frame(16'h0001, 16, -1, '0);
    check_slot(16'hC001, "R5 first word kept");
  endtask

  task automatic t_long_fs;
    int n0;
    push(16'h8001);
    n0 = rx_cnt;
    run_frame(16'hFFFE, 24, -1, '0);
    check_slot(16'h8001, "R2 single slot");
    chk(rx_cnt == n0 + 1, "R2 one slot only", rx_cnt - n0, 1);
    chk(rx_last === 16'hFFFE, "R4 rx word", rx_last, 16'hFFFE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic(16'hA5C3, 16'h1234);
    t_basic(16'h8001, 16'hFFFE);
    t_empty();
    t_midframe();
    t_backpressure();
    t_long_fs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule